// File: doc/BRIEF.md
# Clause-22 PHY Management Frame Master

This block runs single management transactions towards an Ethernet PHY over the two-wire management bus (MDC clock, bidirectional MDIO data). Software loads a clock-rate value, then writes one 32-bit command word. That one write starts a full frame: 32 preamble ones, followed by the command word shifted out most significant bit first. The command word carries the start code, opcode, PHY address, register address, turnaround code and 16 data bits.

For a read opcode the block releases MDIO from the turnaround bits onward. It samples the PHY's answer on each rising MDC edge. At the end of the frame it places the 16 returned bits in the low half of the management data register. Every completed frame sets a sticky event bit, which software clears by writing a one to it. A busy output covers the whole transaction. A rate value of zero freezes MDC and keeps an accepted command waiting.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `mdc` is low, `mdio_oe` is low, `busy` is low, `event_word` is zero and `mgmt_data` is zero.
- R2: One accepted write on `cmd_wdata` produces exactly one frame: 64 rising MDC edges carrying 32 ones and then `cmd_wdata[31]` down to `cmd_wdata[0]`. Each bit is set up while MDC is low.
- R3: With rate value S on `spd_wdata`, MDC is high for S clocks and low for S clocks, so its period is 2*S system clocks.
- R4: When a frame completes, bit 23 of `event_word` becomes 1 in the same cycle that `busy` falls. The bit stays 1 until it is cleared.
- R5: A write on the event port with `ev_wdata[23]`=1 clears bit 23. A write with `ev_wdata[23]`=0 leaves it set.
- R6: When `cmd_wdata[29:28]` is 2'b10 (read), `mdio_oe` is low on the rising edges for command bits 17..0. `mdio_i` is sampled on the 16 rising edges of bits 15..0, first bit received as bit 15. At completion, `mgmt_data[15:0]` holds the received value and `mgmt_data[31:16]` is unchanged.
- R7: `busy` is high from the clock after a command is accepted until completion. A command written while `busy` is high is dropped: it starts no frame and does not change `mgmt_data`.
- R8: While the rate value is zero, MDC does not toggle. An accepted command stays pending with `busy` high, and its frame starts once a nonzero rate is loaded.
- R9: For any opcode other than 2'b10, `mdio_oe` is high on all 64 rising edges. After completion, `mgmt_data` equals the command word written.
- R10: Whenever `busy` is low, `mdc` and `mdio_oe` are both low.

Port `busy`, `mdc`, `mdio_o`, `mdio_oe`, `mgmt_data` and `event_word` are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word: start, opcode, PHY, register, turnaround, data |
| spd_we | input | 1 | Rate value write strobe |
| spd_wdata | input | SPD_W | MDC half-period in system clocks |
| ev_we | input | 1 | Event register write strobe (write-one-to-clear) |
| ev_wdata | input | 32 | Event clear mask, bit 23 = frame done |
| mgmt_data | output | 32 | Management data register |
| event_word | output | 32 | Event register, bit 23 = frame done |
| busy | output | 1 | Transaction accepted and not yet finished |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions assume that `mdio_i` changes only while MDC is low, as a PHY answering on the falling edge would. The bench's PHY model updates `mdio_i` only in the cycle after MDC falls.

They also assume that the rate value is not changed while a frame is running. The stimulus reloads the rate only while `busy` is low, or while a command is held pending at rate zero.

Event-clear writes are issued only when no frame can finish in the same cycle. This keeps the clear assertion free of the set-wins case.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int CMD_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + CMD_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int RD_W       = 16;
  // frame positions (preamble occupies 0..31)
  localparam int TA_IDX     = PRE_BITS + CMD_BITS - RD_W - 2;
  localparam int DATA_IDX   = PRE_BITS + CMD_BITS - RD_W;
  localparam int LAST_IDX   = FRAME_BITS - 1;
  localparam int EVT_BIT    = 23;
  localparam logic [31:0] EVT_MASK = 32'h1 << EVT_BIT;
  localparam logic [1:0]  OP_READ  = 2'b10;

  function automatic logic cmd_is_read(input logic [CMD_BITS-1:0] c);
    return c[29:28] == OP_READ;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int SPD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SPD_W-1:0] spd,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [SPD_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  // half period elapses after spd clocks; zero rate never ticks
  assign tick = run && (spd != '0) && (cnt_q >= spd - SPD_W'(1));
  assign rise = tick && !mdc_q;
  assign fall = tick && mdc_q;
  assign mdc  = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else if (spd != '0) begin
      cnt_q <= cnt_q + SPD_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CMD_BITS-1:0] cmd,
  input  logic                rise,
  input  logic                fall,
  input  logic                mdio_i,
  output logic                mdio_o,
  output logic                mdio_oe,
  output logic                active,
  output logic                done,
  output logic                is_rd,
  output logic [IDX_W-1:0]    idx,
  output logic [RD_W-1:0]     rdata
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic [IDX_W-1:0]      idx_nx;
  logic                  act_q, oe_q, rd_q;
  logic [RD_W-1:0]       cap_q;

  assign idx_nx  = idx_q + IDX_W'(1);
  assign done    = act_q && fall && (idx_q == IDX_W'(LAST_IDX));
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = oe_q;
  assign active  = act_q;
  assign is_rd   = rd_q;
  assign idx     = idx_q;
  assign rdata   = cap_q;

  // shifter, bit counter and drive control
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
      oe_q  <= 1'b0;
      rd_q  <= 1'b0;
    end else if (start) begin
      sh_q  <= {{PRE_BITS{1'b1}}, cmd};
      idx_q <= '0;
      act_q <= 1'b1;
      oe_q  <= 1'b1;
      rd_q  <= cmd_is_read(cmd);
    end else if (act_q && fall) begin
      if (idx_q == IDX_W'(LAST_IDX)) begin
        act_q <= 1'b0;
        oe_q  <= 1'b0;
      end else begin
        idx_q <= idx_nx;
        sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
        oe_q  <= !(rd_q && (idx_nx >= IDX_W'(TA_IDX)));
      end
    end
  end

  // read data capture on rising MDC
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
    end else if (act_q && rise && rd_q && (idx_q >= IDX_W'(DATA_IDX))) begin
      cap_q <= {cap_q[RD_W-2:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int SPD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [31:0]      cmd_wdata,
  input  logic             spd_we,
  input  logic [SPD_W-1:0] spd_wdata,
  input  logic             ev_we,
  input  logic [31:0]      ev_wdata,
  output logic [31:0]      mgmt_data,
  output logic [31:0]      event_word,
  output logic             busy,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic [SPD_W-1:0] spd_q;
  logic [31:0]      data_q;
  logic [31:0]      evt_q;
  logic             busy_q, pend_q;
  logic             frm_start, frm_active, frm_done, frm_rd;
  logic [IDX_W-1:0] frm_idx;
  logic [RD_W-1:0]  frm_rdata;
  logic             mdc_rise, mdc_fall;
  logic [31:0]      clr_mask;

  assign frm_start = pend_q && (spd_q != '0) && !frm_active;
  assign clr_mask  = ev_we ? (ev_wdata & EVT_MASK) : '0;

  // rate register
  always_ff @(posedge clk) begin
    if (rst)         spd_q <= '0;
    else if (spd_we) spd_q <= spd_wdata;
  end

  // event register: completion sets, write-one clears, set wins
  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= (evt_q & ~clr_mask) | (frm_done ? EVT_MASK : '0);
  end

  // command acceptance, pending hold and completion
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (cmd_we && !busy_q) begin
        data_q <= cmd_wdata;
        busy_q <= 1'b1;
        pend_q <= 1'b1;
      end
      if (frm_start) pend_q <= 1'b0;
      if (frm_done) begin
        busy_q <= 1'b0;
        if (frm_rd) data_q[RD_W-1:0] <= frm_rdata;
      end
    end
  end

  mdio_clkgen #(.SPD_W(SPD_W)) u_clk (
    .clk  (clk),
    .rst  (rst),
    .run  (frm_active),
    .spd  (spd_q),
    .mdc  (mdc),
    .rise (mdc_rise),
    .fall (mdc_fall)
  );

  mdio_frame u_frm (
    .clk     (clk),
    .rst     (rst),
    .start   (frm_start),
    .cmd     (data_q),
    .rise    (mdc_rise),
    .fall    (mdc_fall),
    .mdio_i  (mdio_i),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .active  (frm_active),
    .done    (frm_done),
    .is_rd   (frm_rd),
    .idx     (frm_idx),
    .rdata   (frm_rdata)
  );

  assign mgmt_data  = data_q;
  assign event_word = evt_q;
  assign busy       = busy_q;
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_pkg::*;
#(
  parameter int SPD_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_oe,
  input logic [31:0]      event_word,
  input logic             ev_we,
  input logic [31:0]      ev_wdata,
  input logic             cmd_we,
  input logic [31:0]      mgmt_data,
  input logic [SPD_W-1:0] spd_q,
  input logic             frm_done,
  input logic             frm_rd,
  input logic [IDX_W-1:0] frm_idx
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (!mdc && !mdio_oe)); // R10
  AST_EVT_ON_DONE: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> event_word[EVT_BIT]); // R4
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst) (event_word[EVT_BIT] && !(ev_we && ev_wdata[EVT_BIT])) |=> event_word[EVT_BIT]); // R4
  AST_EVT_W1C: assert property (@(posedge clk) disable iff (rst) (ev_we && ev_wdata[EVT_BIT] && !frm_done) |=> !event_word[EVT_BIT]); // R5
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst) (busy && cmd_we && !frm_done) |=> $stable(mgmt_data)); // R7
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst) (busy && frm_rd && (frm_idx >= IDX_W'(TA_IDX))) |-> !mdio_oe); // R6
  AST_SPEED_ZERO: assert property (@(posedge clk) disable iff (rst) (spd_q == '0) |=> $stable(mdc)); // R8
endmodule

bind mdio_mgmt_master mdio_mgmt_chk #(.SPD_W(SPD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .mdc        (mdc),
  .mdio_oe    (mdio_oe),
  .event_word (event_word),
  .ev_we      (ev_we),
  .ev_wdata   (ev_wdata),
  .cmd_we     (cmd_we),
  .mgmt_data  (mgmt_data),
  .spd_q      (spd_q),
  .frm_done   (frm_done),
  .frm_rd     (frm_rd),
  .frm_idx    (frm_idx)
);

// File: tb/sim_mdio_mgmt_master.sv
module sim_mdio_mgmt_master;
  localparam int SPD_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic             cmd_we = 1'b0, spd_we = 1'b0, ev_we = 1'b0;
  logic [31:0]      cmd_wdata = '0, ev_wdata = '0;
  logic [SPD_W-1:0] spd_wdata = '0;
  logic [31:0]      mgmt_data, event_word;
  logic             busy, mdc, mdio_o, mdio_oe;
  logic             mdio_i = 1'b1;

  mdio_mgmt_master #(.SPD_W(SPD_W)) u0 (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .spd_we(spd_we), .spd_wdata(spd_wdata), .ev_we(ev_we), .ev_wdata(ev_wdata),
    .mgmt_data(mgmt_data), .event_word(event_word), .busy(busy), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  typedef struct {
    logic [63:0] frame;
    bit          rd;
    logic [15:0] phy;
    int          spd;
    logic [31:0] exp_data;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  task automatic write_cmd(input logic [31:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic push_cmd(input logic [31:0] c, input int spd, input logic [15:0] phy);
    item_t it;
    it.frame    = {32'hFFFF_FFFF, c};
    it.rd       = (c[29:28] == 2'b10);
    it.phy      = phy;
    it.spd      = spd;
    it.exp_data = it.rd ? {c[31:16], phy} : c;
    q.push_back(it);
    write_cmd(c);
  endtask

  task automatic set_speed(input int s);
    @(negedge clk); spd_we = 1'b1; spd_wdata = SPD_W'(s);
    @(negedge clk); spd_we = 1'b0;
  endtask

  task automatic ev_write(input logic [31:0] m);
    @(negedge clk); ev_we = 1'b1; ev_wdata = m;
    @(negedge clk); ev_we = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
  endtask

  // monitor: PHY model and scoreboard
  initial begin
    item_t cur;
    int    k = 0, cyc = 0, last_rise = 0;
    bit    prev = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst && mdc && !prev) begin
        if (k == 0) begin
          if (q.size() == 0) begin
            chk(1'b0, "R7 unexpected frame", 32'd1, 32'd0);
            cur.frame = '1; cur.rd = 0; cur.phy = '0; cur.spd = 0; cur.exp_data = '0;
          end else begin
            cur = q.pop_front();
          end
        end else begin
          chk(cyc - last_rise == 2 * cur.spd, "R3 mdc period", cyc - last_rise, 2 * cur.spd);
        end
        if (cur.rd && k >= 46) begin
          chk(mdio_oe == 1'b0, "R6 mdio released", mdio_oe, 0);
        end else begin
          chk(mdio_oe == 1'b1, "R9 mdio driven", mdio_oe, 1);
          chk(mdio_o == cur.frame[63-k], (k < 32) ? "R2 preamble bit" : "R2 command bit",
              mdio_o, cur.frame[63-k]);
        end
        last_rise = cyc;
        k++;
      end else if (!rst && !mdc && prev) begin
        chk(cyc - last_rise == cur.spd, "R3 mdc high time", cyc - last_rise, cur.spd);
        if (k == 64) begin
          k = 0;
          mdio_i = 1'b1;
          chk(busy == 1'b0, "R7 busy falls at end", busy, 0);
          chk(event_word[23] == 1'b1, "R4 event set", event_word, 32'h0080_0000);
          chk(mgmt_data == cur.exp_data, cur.rd ? "R6 read data" : "R9 data kept",
              mgmt_data, cur.exp_data);
        end else if (cur.rd && k >= 48) begin
          mdio_i = cur.phy[15-(k-48)];
        end
      end
      prev = mdc;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] ca, cb;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mdc == 0 && mdio_oe == 0, "R1 bus idle after reset", {mdc, mdio_oe}, 0);
    chk(busy == 0, "R1 busy low", busy, 0);
    chk(event_word == 0, "R1 event clear", event_word, 0);
    chk(mgmt_data == 0, "R1 data zero", mgmt_data, 0);
    chk(mdc == 0 && mdio_oe == 0, "R10 idle lines low", {mdc, mdio_oe}, 0);

    // write frame at rate 2
    set_speed(2);
    push_cmd(mk(2'b01, 5'h03, 5'h04, 16'h01E1), 2, 16'h0);
    chk(busy == 1, "R7 busy after accept", busy, 1);
    wait_idle();

    // event write-one-to-clear
    ev_write(32'hFF7F_FFFF);
    chk(event_word[23] == 1, "R5 zero bit keeps event", event_word, 32'h0080_0000);
    chk(event_word[23] == 1, "R4 event sticky", event_word, 32'h0080_0000);
    ev_write(32'h0080_0000);
    chk(event_word[23] == 0, "R5 one bit clears event", event_word, 0);

    // read frame at rate 3
    set_speed(3);
    push_cmd(mk(2'b10, 5'h01, 5'h01, 16'h0000), 3, 16'hA5C3);
    wait_idle();
    ev_write(32'h0080_0000);

    // command while busy is dropped
    set_speed(2);
    ca = mk(2'b01, 5'h1F, 5'h00, 16'h8000);
    cb = mk(2'b10, 5'h02, 5'h11, 16'h1234);
    push_cmd(ca, 2, 16'h0);
    repeat (20) @(negedge clk);
    write_cmd(cb);
    chk(busy == 1, "R7 still busy", busy, 1);
    chk(mgmt_data == ca, "R7 second command ignored", mgmt_data, ca);
    wait_idle();
    repeat (200) @(negedge clk);
    chk(busy == 0 && mdc == 0, "R7 no extra frame", {busy, mdc}, 0);
    chk(mdio_oe == 0, "R10 released when idle", mdio_oe, 0);
    ev_write(32'h0080_0000);

    // rate zero holds the command
    set_speed(0);
    push_cmd(mk(2'b01, 5'h07, 5'h09, 16'hBEEF), 1, 16'h0);
    begin
      bit toggled = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (mdc) toggled = 1;
      end
      chk(!toggled, "R8 mdc frozen at rate zero", toggled, 0);
    end
    chk(busy == 1, "R8 command pending", busy, 1);
    chk(event_word[23] == 0, "R8 no completion while held", event_word, 0);
    set_speed(1);
    wait_idle();
    ev_write(32'h0080_0000);

    // read at a realistic rate ((50/5)+1)<<1
    set_speed(22);
    push_cmd(mk(2'b10, 5'h05, 5'h1E, 16'hFFFF), 22, 16'h1234);
    wait_idle();
    repeat (10) @(negedge clk);

    chk(q.size() == 0, "R2 one frame per command", q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule